// File: doc/BRIEF.md
# Shared Arithmetic Unit Arbiter

This block lets a cluster of independent in-order cores share a small number of pipelined arithmetic units of a single type. The cores are divided statically into equal slices, one slice per unit, so every unit listens only to its own slice and no full crossbar is built. In each cycle any core of a slice may present a request with two operands and a destination tag. The slice arbiter grants one of the requesters, and that operation enters the unit's pipeline. Every other requester in the slice sees its stall flag raised in the same cycle and repeats its request.

Grants rotate round-robin inside each slice. The unit is fully pipelined and can take a new operation every cycle. Each operation travels down the pipeline together with the index of the core that issued it and its tag. When the operation reaches the end, the block raises a one-cycle valid pulse on that core's result port, together with the result and the tag. The arithmetic here is a placeholder integer multiply that keeps the low half of the product.

Top module: `shared_fu_cluster`

## Requirements
- R1: Core c belongs to slice floor(c / (NUM_CORES/NUM_UNITS)) and contends only with cores of its own slice. Cores in different slices that request in the same cycle are all granted.
- R2: In each cycle each slice grants at most one core, grants only a core that requests, and grants some core whenever at least one core in the slice requests.
- R3: The grant goes to the first requesting core at or after a per-slice pointer, searching upward through the local indices with wrap-around. After a grant the pointer moves to the local index one past the granted core. The pointer is 0 after reset.
- R4: A core's stall output is high in exactly the cycles in which it requests and is not granted. The grant and the stall are combinational outputs of the same cycle as the request.
- R5: A result valid pulse lasts one cycle. It appears LATENCY cycles after the cycle of the grant, and only on the port of the core that was granted.
- R6: The returned data equals the low DATA_W bits of the product of the two operands. The returned tag equals the tag presented with the request.
- R7: A unit accepts a new operation in every cycle. A core granted in consecutive cycles receives its results in consecutive cycles.
- R8: A core that keeps requesting is granted within NUM_CORES/NUM_UNITS cycles. Under full load every core of a slice is granted exactly once in any NUM_CORES/NUM_UNITS consecutive cycles.
- R9: While rst_n is low no grant is issued. The first clock edge with rst_n low discards every operation in flight, so no result pulse appears afterwards.
- R10: No two result pulses from the same unit appear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_CORES | Per-core request |
| req_a | input | NUM_CORES*DATA_W | Per-core first operand, core c at bits c*DATA_W upward |
| req_b | input | NUM_CORES*DATA_W | Per-core second operand, same packing |
| req_tag | input | NUM_CORES*TAG_W | Per-core destination tag, core c at bits c*TAG_W upward |
| grant | output | NUM_CORES | Request accepted this cycle |
| stall | output | NUM_CORES | Request held back this cycle |
| res_valid | output | NUM_CORES | One-cycle result pulse for the issuing core |
| res_data | output | NUM_CORES*DATA_W | Result data, packed like req_a |
| res_tag | output | NUM_CORES*TAG_W | Returned tag, packed like req_tag |

## Verification
Two things can happen at once: a grant that issues a new operation into a unit, and a result leaving the same unit for a core of that slice. Back-to-back issue makes this likely. The bench provokes the overlap by keeping a core or a whole slice requesting for several consecutive cycles. While new operations are still being granted and checked, earlier results come out at their end. Each cycle the bench compares every result port against expectations it records, keyed by the due cycle, and it also checks that no unit returns two results in one cycle.

// File: rtl/sfu_pkg.sv
// Package: helpers shared by the shared-unit cluster.
// Assumes: counts passed in are at least 1.
package sfu_pkg;

    // Width of an index into n items; at least one bit so that signals stay legal.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a counter that must hold the values 0..n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return $clog2(n + 2);
    endfunction

endpackage

// File: rtl/sfu_rr_arbiter.sv
// Module: round-robin arbiter for one slice of cores.
// Grants the first requester at or after the pointer and moves the pointer to one past
// the winner. The grant is combinational in the request cycle and is forced to zero
// while reset is low.
// Assumes: N is a power of two; a stalled requester holds its request.
module sfu_rr_arbiter #(
    parameter int unsigned N     = 4,
    parameter int unsigned IDX_W = sfu_pkg::idx_width(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             grant_any
);

    logic [IDX_W-1:0] ptr_q;

    // Search from the pointer upward, with wrap-around, for the first requester.
    always_comb begin
        logic             found;
        logic [IDX_W-1:0] cand;
        found     = 1'b0;
        grant     = '0;
        grant_idx = '0;
        for (int i = 0; i < int'(N); i++) begin
            cand = IDX_W'((int'(ptr_q) + i) % int'(N));
            if (!found && rst_n && req[cand]) begin
                found     = 1'b1;
                grant_idx = cand;
            end
        end
        grant_any = found;
        if (found) grant[grant_idx] = 1'b1;
    end

    // Pointer register: after each grant it points one past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else if (grant_any) ptr_q <= IDX_W'((int'(grant_idx) + 1) % int'(N));
    end

    // R2: one grant at most, only to a requester, and never idle when work is waiting.
    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    assert_work_conserving_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> grant_any);

    // R8: a checker counter per slot bounds how long a held request can wait.
    for (genvar s = 0; s < int'(N); s++) begin : g_fair
        logic [IDX_W:0] wait_q;
        // Count consecutive stalled cycles of this slot; clear on grant or withdrawal.
        always_ff @(posedge clk) begin
            if (!rst_n) wait_q <= '0;
            else if (req[s] && !grant[s]) wait_q <= wait_q + 1'b1;
            else wait_q <= '0;
        end
        assert_bounded_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (req[s] && !grant[s]) |-> (int'(wait_q) < int'(N) - 1));
    end

endmodule

// File: rtl/sfu_pipe_unit.sv
// Module: fully pipelined placeholder arithmetic unit (low half of a*b).
// Each operation carries its local core index and tag through LATENCY register stages.
// Reset clears only the valid bits.
// Assumes: LATENCY >= 1.
module sfu_pipe_unit #(
    parameter int unsigned LATENCY = 2,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned TAG_W   = 5,
    parameter int unsigned IDX_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_idx,
    output logic [DATA_W-1:0] out_data,
    output logic [TAG_W-1:0]  out_tag
);

    localparam int unsigned CNT_W = sfu_pkg::cnt_width(LATENCY);

    logic [LATENCY-1:0] v_q;
    logic [IDX_W-1:0]   idx_q  [LATENCY];
    logic [DATA_W-1:0]  data_q [LATENCY];
    logic [TAG_W-1:0]   tag_q  [LATENCY];
    logic [2*DATA_W-1:0] prod;

    // Full-width product of the operands; only the low half is kept.
    always_comb prod = in_a * in_b;

    // Valid shift chain; cleared by reset so that in-flight work is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else begin
            v_q[0] <= in_valid;
            for (int s = 1; s < int'(LATENCY); s++) v_q[s] <= v_q[s-1];
        end
    end

    // Payload chain: result, core index and tag move with the valid bit.
    always_ff @(posedge clk) begin
        idx_q[0]  <= in_idx;
        data_q[0] <= prod[DATA_W-1:0];
        tag_q[0]  <= in_tag;
        for (int s = 1; s < int'(LATENCY); s++) begin
            idx_q[s]  <= idx_q[s-1];
            data_q[s] <= data_q[s-1];
            tag_q[s]  <= tag_q[s-1];
        end
    end

    assign out_valid = v_q[LATENCY-1];
    assign out_idx   = idx_q[LATENCY-1];
    assign out_data  = data_q[LATENCY-1];
    assign out_tag   = tag_q[LATENCY-1];

    // Checker: operations issued but not yet returned.
    logic [CNT_W-1:0] inflight_q;
    // Track the occupancy from issue and return events.
    always_ff @(posedge clk) begin
        if (!rst_n) inflight_q <= '0;
        else inflight_q <= inflight_q + CNT_W'(in_valid) - CNT_W'(out_valid);
    end

    // R7: occupancy never exceeds one operation per stage.
    assert_occupancy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(inflight_q) <= int'(LATENCY));
    // R5: a result leaves only if something was issued earlier.
    assert_no_phantom_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight_q != '0));

endmodule

// File: rtl/sfu_group.sv
// Module: one slice, made of an arbiter, an operand select and one pipelined unit.
// Assumes: the operand buses are packed with local core i at i*width.
module sfu_group #(
    parameter int unsigned GROUP   = 4,
    parameter int unsigned LATENCY = 2,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned TAG_W   = 5,
    parameter int unsigned IDX_W   = sfu_pkg::idx_width(GROUP)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [GROUP-1:0]        req,
    input  logic [GROUP*DATA_W-1:0] a_bus,
    input  logic [GROUP*DATA_W-1:0] b_bus,
    input  logic [GROUP*TAG_W-1:0]  tag_bus,
    output logic [GROUP-1:0]        grant,
    output logic                    out_valid,
    output logic [IDX_W-1:0]        out_idx,
    output logic [DATA_W-1:0]       out_data,
    output logic [TAG_W-1:0]        out_tag
);

    logic [IDX_W-1:0]  win_idx;
    logic              win_any;
    logic [DATA_W-1:0] sel_a, sel_b;
    logic [TAG_W-1:0]  sel_tag;

    sfu_rr_arbiter #(.N(GROUP), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .grant     (grant),
        .grant_idx (win_idx),
        .grant_any (win_any)
    );

    // Pick the winner's operands and tag for the unit input.
    always_comb begin
        sel_a   = a_bus[int'(win_idx)*DATA_W +: DATA_W];
        sel_b   = b_bus[int'(win_idx)*DATA_W +: DATA_W];
        sel_tag = tag_bus[int'(win_idx)*TAG_W +: TAG_W];
    end

    sfu_pipe_unit #(
        .LATENCY (LATENCY),
        .DATA_W  (DATA_W),
        .TAG_W   (TAG_W),
        .IDX_W   (IDX_W)
    ) u_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (win_any),
        .in_idx    (win_idx),
        .in_a      (sel_a),
        .in_b      (sel_b),
        .in_tag    (sel_tag),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_data  (out_data),
        .out_tag   (out_tag)
    );

endmodule

// File: rtl/shared_fu_cluster.sv
// Module: top level. Splits NUM_CORES cores into NUM_UNITS static slices, each slice
// with one pipelined unit, and steers every result back to the core that issued it.
// Assumes: NUM_UNITS is a power of two that divides NUM_CORES.
module shared_fu_cluster #(
    parameter int unsigned NUM_CORES = 32,
    parameter int unsigned NUM_UNITS = 8,
    parameter int unsigned LATENCY   = 2,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned TAG_W     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES-1:0]        req_valid,
    input  logic [NUM_CORES*DATA_W-1:0] req_a,
    input  logic [NUM_CORES*DATA_W-1:0] req_b,
    input  logic [NUM_CORES*TAG_W-1:0]  req_tag,
    output logic [NUM_CORES-1:0]        grant,
    output logic [NUM_CORES-1:0]        stall,
    output logic [NUM_CORES-1:0]        res_valid,
    output logic [NUM_CORES*DATA_W-1:0] res_data,
    output logic [NUM_CORES*TAG_W-1:0]  res_tag
);

    localparam int unsigned GROUP = NUM_CORES / NUM_UNITS;
    localparam int unsigned IDX_W = sfu_pkg::idx_width(GROUP);

    for (genvar g = 0; g < int'(NUM_UNITS); g++) begin : g_unit
        logic [GROUP-1:0]  gnt;
        logic              ov;
        logic [IDX_W-1:0]  oi;
        logic [DATA_W-1:0] od;
        logic [TAG_W-1:0]  ot;

        sfu_group #(
            .GROUP   (GROUP),
            .LATENCY (LATENCY),
            .DATA_W  (DATA_W),
            .TAG_W   (TAG_W),
            .IDX_W   (IDX_W)
        ) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_valid[g*GROUP +: GROUP]),
            .a_bus     (req_a[g*GROUP*DATA_W +: GROUP*DATA_W]),
            .b_bus     (req_b[g*GROUP*DATA_W +: GROUP*DATA_W]),
            .tag_bus   (req_tag[g*GROUP*TAG_W +: GROUP*TAG_W]),
            .grant     (gnt),
            .out_valid (ov),
            .out_idx   (oi),
            .out_data  (od),
            .out_tag   (ot)
        );

        assign grant[g*GROUP +: GROUP] = gnt;
        assign stall[g*GROUP +: GROUP] = req_valid[g*GROUP +: GROUP] & ~gnt;

        // Result steering: only the core whose local index matches sees the pulse.
        for (genvar i = 0; i < int'(GROUP); i++) begin : g_core
            assign res_valid[g*GROUP + i]                = ov && (oi == IDX_W'(i));
            assign res_data[(g*GROUP + i)*DATA_W +: DATA_W] = od;
            assign res_tag[(g*GROUP + i)*TAG_W +: TAG_W]    = ot;
        end

        // R10: a unit returns at most one result per cycle across its slice.
        assert_single_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(res_valid[g*GROUP +: GROUP]));
    end

    // Checker: remembers that the previous edge saw reset.
    logic was_reset;
    // Record whether reset was low at the last edge.
    always_ff @(posedge clk) was_reset <= !rst_n;

    // R9: the edge in reset emptied every pipeline, so no result may show.
    always @(posedge clk) begin
        if (was_reset === 1'b1)
            assert_reset_quiet_R9: assert (res_valid == '0);
    end

endmodule

// File: tb/shared_fu_cluster_test.sv
`timescale 1ns/1ps
module shared_fu_cluster_test;

    localparam int NC  = 32;
    localparam int NU  = 8;
    localparam int LAT = 2;
    localparam int DW  = 16;
    localparam int TW  = 5;
    localparam int G   = NC / NU;
    localparam int SLOTS = 64;

    // Table for slice 0: {request mask[3:0], expect grant, expected local index[1:0]}.
    localparam int NVEC = 12;
    localparam logic [6:0] VEC [NVEC] = '{
        7'b1111_1_00, 7'b1111_1_01, 7'b1111_1_10, 7'b1111_1_11,
        7'b0100_1_10, 7'b0011_1_00, 7'b0000_0_00, 7'b1001_1_11,
        7'b1010_1_01, 7'b0010_1_01, 7'b1000_1_11, 7'b0001_1_00
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [NC-1:0]    req_valid;
    logic [NC*DW-1:0] req_a, req_b;
    logic [NC*TW-1:0] req_tag;
    logic [NC-1:0]    grant, stall, res_valid;
    logic [NC*DW-1:0] res_data;
    logic [NC*TW-1:0] res_tag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic          exp_v [SLOTS][NC];
    logic [DW-1:0] exp_d [SLOTS][NC];
    logic [TW-1:0] exp_t [SLOTS][NC];

    shared_fu_cluster #(.NUM_CORES(NC), .NUM_UNITS(NU), .LATENCY(LAT),
                        .DATA_W(DW), .TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_a(req_a),
        .req_b(req_b), .req_tag(req_tag), .grant(grant), .stall(stall),
        .res_valid(res_valid), .res_data(res_data), .res_tag(res_tag)
    );

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] op_a(int c, int k);
        return DW'(c * 7 + k * 3 + 1);
    endfunction
    function automatic logic [DW-1:0] op_b(int c, int k);
        return DW'(k + 2 + c * 5);
    endfunction
    function automatic logic [TW-1:0] op_t(int c, int k);
        return TW'(c + k);
    endfunction

    // Present a request from core c with stimulus number k.
    task automatic put_req(int c, int k);
        req_valid[c]         = 1'b1;
        req_a[c*DW +: DW]    = op_a(c, k);
        req_b[c*DW +: DW]    = op_b(c, k);
        req_tag[c*TW +: TW]  = op_t(c, k);
    endtask

    // Record the result expected from core c, granted this cycle (R5, R6).
    task automatic expect_res(int c, int k);
        logic [2*DW-1:0] p;
        int s;
        p = op_a(c, k) * op_b(c, k);
        s = (cyc + LAT) % SLOTS;
        exp_v[s][c] = 1'b1;
        exp_d[s][c] = p[DW-1:0];
        exp_t[s][c] = op_t(c, k);
    endtask

    task automatic check(bit ok, string req, string msg, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h (cycle %0d)", req, msg, act, expv, cyc);
        end
    endtask

    // Compare every result port against the expectations due this cycle (R5, R6, R10).
    task automatic check_results();
        int s;
        bit ok;
        logic [NC-1:0] ev;
        s = cyc % SLOTS;
        ok = 1'b1;
        for (int c = 0; c < NC; c++) begin
            ev[c] = exp_v[s][c];
            if (exp_v[s][c] && res_valid[c]) begin
                if (res_data[c*DW +: DW] !== exp_d[s][c])
                    check(1'b0, "R6", $sformatf("data core %0d", c),
                          64'(res_data[c*DW +: DW]), 64'(exp_d[s][c]));
                if (res_tag[c*TW +: TW] !== exp_t[s][c])
                    check(1'b0, "R6", $sformatf("tag core %0d", c),
                          64'(res_tag[c*TW +: TW]), 64'(exp_t[s][c]));
            end
            exp_v[s][c] = 1'b0;
        end
        if (res_valid !== ev) ok = 1'b0;
        check(ok, "R5", "result valid pattern", 64'(res_valid), 64'(ev));
        for (int g = 0; g < NU; g++)
            check($countones(res_valid[g*G +: G]) <= 1, "R10", "one return per unit",
                  64'(res_valid[g*G +: G]), 64'(0));
    endtask

    // Advance one cycle, then check results away from the active edge.
    task automatic step();
        @(posedge clk);
        cyc++;
        @(negedge clk);
        check_results();
    endtask

    task automatic clear_reqs();
        req_valid = '0;
    endtask

    initial begin
        int cnt [NC];
        rst_n = 1'b0;
        req_valid = '0; req_a = '0; req_b = '0; req_tag = '0;
        for (int s = 0; s < SLOTS; s++)
            for (int c = 0; c < NC; c++) begin
                exp_v[s][c] = 1'b0; exp_d[s][c] = '0; exp_t[s][c] = '0;
            end
        step(); step();
        // R9: reset state has no grants and no results, even with requests present.
        put_req(3, 0); put_req(17, 0);
        #1;
        check(grant == '0, "R9", "no grant in reset", 64'(grant), 64'(0));
        check(res_valid == '0, "R9", "no result in reset", 64'(res_valid), 64'(0));
        step();
        clear_reqs();
        rst_n = 1'b1;
        step(); step(); step();

        // Table walk on slice 0: round-robin order, stall flags and result return (R2, R3, R4).
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] m;
            logic [3:0] eg;
            m  = VEC[v][6:3];
            eg = VEC[v][2] ? (4'b0001 << VEC[v][1:0]) : 4'b0000;
            clear_reqs();
            for (int i = 0; i < G; i++) if (m[i]) put_req(i, v);
            #1;
            check(grant[3:0] == eg, "R3", $sformatf("rr grant vector %0d", v),
                  64'(grant[3:0]), 64'(eg));
            check(stall[3:0] == (m & ~eg), "R4", $sformatf("stall vector %0d", v),
                  64'(stall[3:0]), 64'(m & ~eg));
            check(grant[NC-1:4] == '0, "R2", "no grant without request",
                  64'(grant[NC-1:4]), 64'(0));
            if (VEC[v][2]) expect_res(int'(VEC[v][1:0]), v);
            step();
        end
        clear_reqs();
        step(); step(); step();

        // R1: one core in each of three slices, all granted together.
        put_req(1, 20); put_req(4, 20); put_req(31, 20);
        #1;
        check(grant == ((32'd1 << 1) | (32'd1 << 4) | (32'd1 << 31)), "R1",
              "independent slices", 64'(grant), 64'((32'd1 << 1) | (32'd1 << 4) | (32'd1 << 31)));
        expect_res(1, 20); expect_res(4, 20); expect_res(31, 20);
        step();
        clear_reqs();
        step(); step(); step();

        // R7: one core issues in three consecutive cycles; results arrive back to back.
        for (int k = 0; k < 3; k++) begin
            clear_reqs();
            put_req(13, 30 + k);
            #1;
            check(grant[13] === 1'b1, "R7", "back-to-back grant", 64'(grant[13]), 64'(1));
            expect_res(13, 30 + k);
            step();
        end
        clear_reqs();
        step(); step(); step();

        // R8: every core requests for G cycles; each must be granted exactly once.
        for (int c = 0; c < NC; c++) cnt[c] = 0;
        for (int k = 0; k < G; k++) begin
            clear_reqs();
            for (int c = 0; c < NC; c++) if (cnt[c] == 0) put_req(c, 40);
            #1;
            for (int c = 0; c < NC; c++)
                if (grant[c]) begin
                    cnt[c]++;
                    expect_res(c, 40);
                end
            step();
        end
        clear_reqs();
        for (int c = 0; c < NC; c++)
            check(cnt[c] == 1, "R8", $sformatf("grants to core %0d in window", c),
                  64'(cnt[c]), 64'(1));
        step(); step(); step();

        // R9: an operation in flight is dropped by reset, and reset blocks new grants.
        put_req(8, 50);
        #1;
        check(grant[8] === 1'b1, "R9", "grant before reset", 64'(grant[8]), 64'(1));
        step();
        clear_reqs();
        rst_n = 1'b0;
        put_req(9, 51);
        #1;
        check(grant == '0, "R9", "grant masked in reset", 64'(grant), 64'(0));
        step();
        clear_reqs();
        rst_n = 1'b1;
        for (int k = 0; k < LAT + 2; k++) step();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule